// File: doc/BRIEF.md
# Serial Word Transmitter

This block turns parallel sample words into a serial bit stream, most significant bit first. The bit clock and the frame sync come from outside the block and are sampled with the system clock. A programmable word length and a programmable count of words per frame set the frame shape. An optional one-bit gap can sit between the sync and the first data bit, and a polarity control picks which bit clock edge launches data. A single holding register takes words from a host or DMA engine and asks for the next word whenever it is empty.

The block flags two faults. The first is a frame sync that arrives while a frame is still being sent, and an ignore control can mask it. The second is an empty holding register at the moment a word must start. A local enable works as the transmitter's own reset. Leaving that reset needs at least one bit clock edge while the enable is still low. The configuration inputs are expected to stay steady while a frame is in progress.

Top module: `serial_word_tx`

## Requirements
- R1: After the synchronous reset `sdout`, `sync_err` and `underrun` are 0 and `req` is 1.
- R2: `wlen` selects the word length: 0→8, 1→12, 2→16, 3→20, 4→24, 5→32 bits. The word is taken from the low bits of `wr_data` and is sent MSB first, one bit per launch edge.
- R3: A frame carries `frlen`+1 words back to back with no gap between them. After the last bit of the frame, `sdout` is 0 on every launch edge until the next sync starts a frame.
- R4: With `dly`=0 the MSB is driven on the launch edge at which `fs` is sampled high. With `dly`=1 that edge drives 0 and the MSB follows on the next launch edge.
- R5: With `pol`=0 data changes only on rising `bclk` edges. With `pol`=1 it changes only on falling edges. The other edge leaves `sdout` unchanged.
- R6: `req` is 1 exactly when the holding register is empty. A write with `req`=1 is stored and drops `req` on the next cycle. A write while `req`=0 is discarded. The register is emptied when its word is loaded at a word start.
- R7: If the holding register is empty at a word start, the previous word is sent again and the sticky `underrun` flag is set.
- R8: An `fs` sampled high during a frame is unexpected and sets the sticky `sync_err` flag. It also aborts the frame, so `sdout` is 0 until a new sync arrives. The one exception is with `dly`=1, when `fs` is high on the edge that drives the frame's last bit. That sync is accepted and starts the next frame.
- R9: With `ign`=1 an unexpected `fs` has no effect, and the frame completes unchanged.
- R10: With `en`=0 the transmitter is idle, `sdout` is 0 and both flags are cleared. After `en` falls, frames start only once a `bclk` edge has been seen while `en` is low.
- R11: `wlen` codes 6 and 7 select 32-bit words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Transmitter enable; low holds the transmitter in reset |
| wlen | input | 3 | Word length code |
| frlen | input | FRW | Words per frame minus one |
| dly | input | 1 | One-bit data delay after sync |
| pol | input | 1 | Launch edge select: 0 rising, 1 falling |
| ign | input | 1 | Ignore unexpected frame syncs |
| bclk | input | 1 | Bit clock, sampled by clk |
| fs | input | 1 | Frame sync, sampled on launch edges |
| wr_en | input | 1 | Holding register write strobe |
| wr_data | input | 32 | Word to send, low-bit justified |
| req | output | 1 | Holding register empty, next word requested |
| sdout | output | 1 | Serial data out |
| sync_err | output | 1 | Sticky unexpected-sync flag |
| underrun | output | 1 | Sticky empty-at-word-start flag |

## Verification
A wrong bit counter or a wrong word-length decode shows up as a misaligned or truncated word at `sdout` within one frame. It also leaves a spurious 1 or 0 on the first idle launch edge after the frame. A wrong frame-state decision about a sync appears at once: `sync_err` rises when it should not, or an aborted frame keeps driving data on the next launch edge. Errors in holding-register bookkeeping reach `req` one cycle after a write. At the next word start they show as a repeated or lost word.

// File: rtl/swtx_pkg.sv
package swtx_pkg;

    localparam int MAXW = 32;
    localparam int CNTW = 6;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } tx_state_e;

    typedef struct packed {
        logic [2:0] wcode;
        logic       dly;
        logic       ign;
    } tx_cfg_t;

    function automatic logic [CNTW-1:0] word_bits(input logic [2:0] code);
        case (code)
            3'd0:    return CNTW'(8);
            3'd1:    return CNTW'(12);
            3'd2:    return CNTW'(16);
            3'd3:    return CNTW'(20);
            3'd4:    return CNTW'(24);
            default: return CNTW'(32);
        endcase
    endfunction

endpackage

// File: rtl/swtx_edge.sv
module swtx_edge (
    input  logic clk,
    input  logic rst,
    input  logic bclk,
    input  logic pol,
    output logic any_edge,
    output logic tick
);
    logic bclk_q;

    always_ff @(posedge clk) begin
        if (rst) bclk_q <= 1'b0;
        else     bclk_q <= bclk;
    end

    assign any_edge = bclk ^ bclk_q;
    assign tick     = any_edge && (bclk != pol);
endmodule

// File: rtl/swtx_hold.sv
module swtx_hold #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          pull,
    output logic          full,
    output logic [DW-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else if (wr_en && !full) begin
            full <= 1'b1;
            data <= wr_data;
        end else if (pull) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/swtx_framer.sv
module swtx_framer
    import swtx_pkg::*;
#(
    parameter int FRW = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            tick,
    input  logic            any_edge,
    input  logic            fs,
    input  tx_cfg_t         cfg,
    input  logic [FRW-1:0]  frlen,
    input  logic            hold_full,
    input  logic [MAXW-1:0] hold_data,
    output logic            pull,
    output logic            sdout,
    output logic            sync_err,
    output logic            underrun
);
    tx_state_e       state;
    logic [MAXW-1:0] sh;
    logic [MAXW-1:0] last_word;
    logic [CNTW-1:0] left;
    logic [FRW-1:0]  wcnt;
    logic            armed;
    logic            en_q;

    logic [CNTW-1:0] wl;
    logic [CNTW:0]   shamt;
    logic [MAXW-1:0] src;
    logic [MAXW-1:0] al;
    logic            last_bit;
    logic            final_bit;
    logic            chain;
    logic            abort;
    logic            step;

    always_comb begin
        wl        = word_bits(cfg.wcode);
        shamt     = (CNTW+1)'(MAXW) - {1'b0, wl};
        src       = hold_full ? hold_data : last_word;
        al        = src << shamt;
        last_bit  = (left == CNTW'(1));
        final_bit = last_bit && (wcnt == frlen);
        chain     = cfg.dly && final_bit && fs;
        abort     = (state == ST_BUSY) && fs && !cfg.ign && !(cfg.dly && final_bit);
        step      = en && armed && tick;
        pull      = step && (((state == ST_IDLE) && fs) ||
                             ((state == ST_BUSY) && !abort && last_bit &&
                              ((wcnt != frlen) || chain)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            sh        <= '0;
            last_word <= '0;
            left      <= '0;
            wcnt      <= '0;
            sdout     <= 1'b0;
            sync_err  <= 1'b0;
            underrun  <= 1'b0;
            armed     <= 1'b0;
            en_q      <= 1'b0;
        end else begin
            en_q <= en;
            if (!en) begin
                state    <= ST_IDLE;
                sdout    <= 1'b0;
                sync_err <= 1'b0;
                underrun <= 1'b0;
                if (en_q)          armed <= 1'b0;
                else if (any_edge) armed <= 1'b1;
            end else if (step) begin
                case (state)
                    ST_IDLE: begin
                        sdout <= 1'b0;
                        if (fs) begin
                            state <= ST_BUSY;
                            wcnt  <= '0;
                            if (!cfg.dly) begin
                                sdout <= al[MAXW-1];
                                sh    <= al << 1;
                                left  <= wl - CNTW'(1);
                            end else begin
                                sh    <= al;
                                left  <= wl;
                            end
                        end
                    end
                    default: begin
                        if (abort) begin
                            sync_err <= 1'b1;
                            state    <= ST_IDLE;
                            sdout    <= 1'b0;
                        end else begin
                            sdout <= sh[MAXW-1];
                            sh    <= sh << 1;
                            left  <= left - CNTW'(1);
                            if (last_bit) begin
                                if (wcnt != frlen) begin
                                    sh   <= al;
                                    left <= wl;
                                    wcnt <= wcnt + FRW'(1);
                                end else if (chain) begin
                                    sh   <= al;
                                    left <= wl;
                                    wcnt <= '0;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                        end
                    end
                endcase
                if (pull) begin
                    last_word <= src;
                    if (!hold_full) underrun <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/serial_word_tx.sv
module serial_word_tx
    import swtx_pkg::*;
#(
    parameter int FRW = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [2:0]      wlen,
    input  logic [FRW-1:0]  frlen,
    input  logic            dly,
    input  logic            pol,
    input  logic            ign,
    input  logic            bclk,
    input  logic            fs,
    input  logic            wr_en,
    input  logic [MAXW-1:0] wr_data,
    output logic            req,
    output logic            sdout,
    output logic            sync_err,
    output logic            underrun
);
    logic            any_edge;
    logic            tick;
    logic            pull;
    logic            hold_full;
    logic [MAXW-1:0] hold_data;
    tx_cfg_t         cfg;

    assign cfg = '{wcode: wlen, dly: dly, ign: ign};
    assign req = !hold_full;

    swtx_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .bclk     (bclk),
        .pol      (pol),
        .any_edge (any_edge),
        .tick     (tick)
    );

    swtx_hold #(.DW(MAXW)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .pull    (pull),
        .full    (hold_full),
        .data    (hold_data)
    );

    swtx_framer #(.FRW(FRW)) u_framer (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .tick      (tick),
        .any_edge  (any_edge),
        .fs        (fs),
        .cfg       (cfg),
        .frlen     (frlen),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .pull      (pull),
        .sdout     (sdout),
        .sync_err  (sync_err),
        .underrun  (underrun)
    );
endmodule

// File: rtl/swtx_chk.sv
module swtx_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic launch,
    input logic sdout,
    input logic sync_err,
    input logic underrun,
    input logic req,
    input logic wr_en
);
    p_idle_low_r10: assert property (@(posedge clk) disable iff (rst)
        !en |=> !sdout);

    p_flags_clear_r10: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!sync_err && !underrun));

    p_edge_only_r5: assert property (@(posedge clk) disable iff (rst)
        (en && !launch) |=> $stable(sdout));

    p_req_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && req) |=> !req);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (en && sync_err) |=> sync_err);

    p_under_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (en && underrun) |=> underrun);
endmodule

bind serial_word_tx swtx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .launch   (tick),
    .sdout    (sdout),
    .sync_err (sync_err),
    .underrun (underrun),
    .req      (req),
    .wr_en    (wr_en)
);

// File: tb/serial_word_tx_tb.sv
`timescale 1ns/1ps
module serial_word_tx_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [2:0]  wlen = 3'd2;
    logic [3:0]  frlen = 4'd0;
    logic        dly = 1'b0;
    logic        pol = 1'b0;
    logic        ign = 1'b0;
    logic        bclk = 1'b0;
    logic        fs = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        req, sdout, sync_err, underrun;

    int   n_chk = 0;
    int   n_bad = 0;
    logic after_b;

    always #10 clk = ~clk;

    serial_word_tx u_dut (
        .clk(clk), .rst(rst), .en(en), .wlen(wlen), .frlen(frlen), .dly(dly),
        .pol(pol), .ign(ign), .bclk(bclk), .fs(fs), .wr_en(wr_en),
        .wr_data(wr_data), .req(req), .sdout(sdout), .sync_err(sync_err),
        .underrun(underrun)
    );

    localparam logic [2:0]  CODES [8] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
    localparam int          EXPW  [8] = '{8, 12, 16, 20, 24, 32, 32, 32};
    localparam logic [31:0] WORDS [8] = '{32'h0000_00B6, 32'h0000_0A5C, 32'h0000_E817,
                                          32'h000F_0F3C, 32'h00C3_5A96, 32'h8123_4567,
                                          32'hDEAD_BEEF, 32'h7F00_00FE};

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic launch(input logic fsv, output logic b);
        @(negedge clk); fs = fsv; bclk = ~pol;
        @(negedge clk); b = sdout; fs = 1'b0; bclk = pol;
        @(negedge clk); after_b = sdout;
    endtask

    task automatic write(input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rx(input int nbits, input logic first_fs, output logic [63:0] v);
        logic b;
        v = '0;
        for (int i = 0; i < nbits; i++) begin
            launch((i == 0) ? first_fs : 1'b0, b);
            v = {v[62:0], b};
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] v;
        logic        b;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 sdout", 64'(sdout), 64'd0);
        chk("R1 req", 64'(req), 64'd1);
        chk("R1 sync_err", 64'(sync_err), 64'd0);
        chk("R1 underrun", 64'(underrun), 64'd0);

        launch(1'b0, b);
        @(negedge clk); en = 1'b1;

        // R2 / R11 table walk, one word per frame
        for (int i = 0; i < 8; i++) begin
            write(WORDS[i]);
            @(negedge clk); wlen = CODES[i];
            rx(EXPW[i], 1'b1, v);
            chk($sformatf("R2 R11 word %0d", i), v, 64'(WORDS[i]) & ((64'd1 << EXPW[i]) - 64'd1));
            launch(1'b0, b);
            chk("R3 idle after frame", 64'(b), 64'd0);
        end
        wlen = 3'd2;

        // R4 one-bit delay
        dly = 1'b1;
        write(32'hC3A5);
        launch(1'b1, b);
        chk("R4 delay edge", 64'(b), 64'd0);
        rx(16, 1'b0, v);
        chk("R4 delayed word", v, 64'hC3A5);
        dly = 1'b0;

        // R3 stereo frame, second word written mid-frame
        frlen = 4'd1;
        write(32'h1234);
        launch(1'b1, b);
        chk("R6 req after load", 64'(req), 64'd1);
        write(32'hABCD);
        rx(31, 1'b0, v);
        v = {31'd0, b, v[30:0]};
        chk("R3 two words", v, 64'h1234ABCD);
        launch(1'b0, b);
        chk("R3 idle after stereo", 64'(b), 64'd0);
        frlen = 4'd0;

        // R6 write while full discarded
        write(32'h5555);
        chk("R6 req low when full", 64'(req), 64'd0);
        write(32'h0F0F);
        rx(16, 1'b1, v);
        chk("R6 first word kept", v, 64'h5555);

        // R7 underrun
        chk("R7 no underrun yet", 64'(underrun), 64'd0);
        rx(16, 1'b1, v);
        chk("R7 repeated word", v, 64'h5555);
        chk("R7 underrun flag", 64'(underrun), 64'd1);

        // R8 expected sync on last bit with delay 1
        dly = 1'b1;
        write(32'h8001);
        launch(1'b1, b);
        write(32'h7FFE);
        v = '0;
        for (int i = 0; i < 16; i++) begin
            launch(i == 15, b);
            v = {v[62:0], b};
        end
        chk("R8 chained first", v, 64'h8001);
        chk("R8 expected sync no error", 64'(sync_err), 64'd0);
        rx(16, 1'b0, v);
        chk("R8 chained second", v, 64'h7FFE);
        dly = 1'b0;

        // R8 unexpected sync aborts
        write(32'hFFFF);
        rx(3, 1'b1, v);
        launch(1'b1, b);
        chk("R8 sync_err set", 64'(sync_err), 64'd1);
        chk("R8 abort sdout", 64'(b), 64'd0);
        launch(1'b0, b);
        chk("R8 stays idle", 64'(b), 64'd0);

        // R10 disable clears, rearm needs an edge
        @(negedge clk); en = 1'b0;
        @(negedge clk);
        chk("R10 sync_err cleared", 64'(sync_err), 64'd0);
        chk("R10 underrun cleared", 64'(underrun), 64'd0);
        chk("R10 sdout low", 64'(sdout), 64'd0);
        en = 1'b1;
        write(32'h2468);
        rx(4, 1'b1, v);
        chk("R10 unarmed silent", v, 64'd0);
        chk("R10 word not taken", 64'(req), 64'd0);
        @(negedge clk); en = 1'b0;
        launch(1'b0, b);
        @(negedge clk); en = 1'b1;
        rx(16, 1'b1, v);
        chk("R10 rearmed frame", v, 64'h2468);

        // R9 ignore unexpected sync
        ign = 1'b1;
        write(32'h9669);
        v = '0;
        for (int i = 0; i < 16; i++) begin
            launch((i == 0) || (i == 4), b);
            v = {v[62:0], b};
        end
        chk("R9 word intact", v, 64'h9669);
        chk("R9 no error", 64'(sync_err), 64'd0);
        ign = 1'b0;

        // R5 falling-edge launch
        @(negedge clk); en = 1'b0;
        @(negedge clk); pol = 1'b1; bclk = 1'b1;
        @(negedge clk); en = 1'b1; wlen = 3'd0;
        write(32'hA5);
        v = '0;
        for (int i = 0; i < 8; i++) begin
            launch(i == 0, b);
            v = {v[62:0], b};
            if (i == 2) chk("R5 other edge no change", 64'(after_b), 64'(b));
        end
        chk("R5 falling-edge word", v, 64'hA5);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule